// File: doc/BRIEF.md
# GPIO Pin Interrupt Qualifier

This block sits behind the input synchronizers of a general-purpose port. Once per clock it samples every pin that is configured as an enabled input and keeps the result as a data word. From each pin's previous and new sampled level it decides whether the pin raises an interrupt. Each pin has its own trigger style: level-sensitive with selectable active level, a single edge with selectable direction, or any change of level.

The triggering pins are gated by two independent route words and ORed into two registered interrupt requests, A and B. One pin can feed either request, both or neither. The control words are plain inputs held by a register file elsewhere. Pins set as outputs, and pins whose input enable is low, keep their stored level and never interrupt.

Top module: `gpio_irq_qualifier`

## Requirements
- R1: While `rst_n` is low at a clock edge, `sample_q`, `irq_a` and `irq_b` are cleared to 0.
- R2: For a pin with `pin_dir` bit 0 (input) and `pin_en` bit 1, each rising clock edge loads that pin's `pin_in` level into its `sample_q` bit.
- R3: A pin with `pin_dir` bit 1 or `pin_en` bit 0 keeps its `sample_q` bit, and no change on its input raises `irq_a` or `irq_b`.
- R4: With `edge_sel` bit 1 and `any_edge` bit 1, a pin triggers when its new level differs from its stored level, in either direction, and does not trigger when the two are equal.
- R5: With `edge_sel` bit 1 and `any_edge` bit 0, `polarity` bit 0 triggers only on a 0-to-1 change and `polarity` bit 1 triggers only on a 1-to-0 change.
- R6: With `edge_sel` bit 0 (level mode), a pin triggers on every clock where its new level differs from its `polarity` bit: high is active when `polarity` is 0, and low is active when `polarity` is 1.
- R7: A triggering pin drives `irq_a` when its `route_a` bit is 1 and `irq_b` when its `route_b` bit is 1. Both may fire from one pin, and a pin routed nowhere fires neither.
- R8: The interrupt outputs are registered. They update on the same clock edge that loads the sample, so an edge trigger gives a one-cycle pulse and a held level gives a steady request.
- R9: Each interrupt output is the OR over all pins of their routed triggers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_in | input | 16 | Synchronized pin levels |
| pin_dir | input | 16 | 1 = pin is an output (sampling disabled) |
| pin_en | input | 16 | 1 = input buffer enabled |
| polarity | input | 16 | Active level / edge direction select |
| edge_sel | input | 16 | 1 = edge-sensitive, 0 = level-sensitive |
| any_edge | input | 16 | 1 = trigger on either edge (edge mode only) |
| route_a | input | 16 | Per-pin enable towards `irq_a` |
| route_b | input | 16 | Per-pin enable towards `irq_b` |
| sample_q | output | 16 | Stored sampled pin levels |
| irq_a | output | 1 | Registered interrupt request A |
| irq_b | output | 1 | Registered interrupt request B |

## Verification
The stored sample is the only memory in each pin. A wrong stored bit shows at `sample_q` one edge after it is loaded. In edge modes it also shows as a missing or extra interrupt pulse on the next input change. A fault in the mode decode or the routing shows up on `irq_a` or `irq_b` in the same cycle the sample updates. The bench therefore checks the outputs one edge after each stimulus, and checks again one edge later, to tell a one-cycle pulse from a steady level request.

// File: rtl/gpio_irq_pkg.sv
// Package: shared trigger-style type and its decode for the pin qualifier.
// Assumes edge/any-edge control bits come straight from configuration.
package gpio_irq_pkg;

    typedef enum logic [1:0] {
        TRIG_LEVEL  = 2'd0,
        TRIG_SINGLE = 2'd1,
        TRIG_ANY    = 2'd2
    } trig_kind_e;

    // Map the two per-pin style bits to a trigger kind.
    function automatic trig_kind_e pick_kind(input logic edge_bit, input logic any_bit);
        if (!edge_bit)
            return TRIG_LEVEL;
        else if (any_bit)
            return TRIG_ANY;
        else
            return TRIG_SINGLE;
    endfunction

endpackage

// File: rtl/gpio_pin_cell.sv
// Module: one pin's sample register and trigger decision.
// Keeps the stored level and computes a combinational trigger from the
// stored (old) and incoming (new) level. Assumes pin_lvl is synchronized.
module gpio_pin_cell
    import gpio_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pin_lvl,
    input  logic is_output,
    input  logic buf_en,
    input  logic pol,
    input  logic edge_bit,
    input  logic any_bit,
    output logic stored,
    output logic trig
);

    logic       live;
    trig_kind_e kind;

    assign live = !is_output && buf_en;
    assign kind = pick_kind(edge_bit, any_bit);

    // Load the new level for live pins; hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)
            stored <= 1'b0;
        else if (live)
            stored <= pin_lvl;
    end

    // Decide whether the old-to-new transition (or level) triggers.
    always_comb begin
        trig = 1'b0;
        if (live) begin
            unique case (kind)
                TRIG_LEVEL:  trig = (pin_lvl != pol);
                TRIG_ANY:    trig = (pin_lvl != stored);
                TRIG_SINGLE: trig = pol ? (stored && !pin_lvl) : (!stored && pin_lvl);
                default:     trig = 1'b0;
            endcase
        end
    end

    // R3: a disabled pin keeps its stored level.
    p_hold_disabled_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (is_output || !buf_en) |=> $stable(stored));

    // R2: a live pin's stored level follows its input one edge later.
    p_capture_live_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_output && buf_en) |=> (stored == $past(pin_lvl)));

endmodule

// File: rtl/gpio_irq_merge.sv
// Module: routes per-pin triggers through two mask words and registers
// the ORed results as the two interrupt requests.
module gpio_irq_merge #(
    parameter int PINS = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PINS-1:0] trig_vec,
    input  logic [PINS-1:0] mask_a,
    input  logic [PINS-1:0] mask_b,
    output logic            req_a,
    output logic            req_b
);

    // Register the OR of the routed triggers for each request line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_a <= 1'b0;
            req_b <= 1'b0;
        end else begin
            req_a <= |(trig_vec & mask_a);
            req_b <= |(trig_vec & mask_b);
        end
    end

    // R7: an empty route word never lets request A fire.
    p_no_route_a_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_a == '0) |=> !req_a);

    // R7: an empty route word never lets request B fire.
    p_no_route_b_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_b == '0) |=> !req_b);

endmodule

// File: rtl/gpio_irq_qualifier.sv
// Module: top of the pin interrupt qualifier. Instantiates one pin cell
// per pin and the request merger. Assumes all inputs are synchronous to
// clk; control words may change on any cycle.
module gpio_irq_qualifier #(
    parameter int PINS = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PINS-1:0] pin_in,
    input  logic [PINS-1:0] pin_dir,
    input  logic [PINS-1:0] pin_en,
    input  logic [PINS-1:0] polarity,
    input  logic [PINS-1:0] edge_sel,
    input  logic [PINS-1:0] any_edge,
    input  logic [PINS-1:0] route_a,
    input  logic [PINS-1:0] route_b,
    output logic [PINS-1:0] sample_q,
    output logic            irq_a,
    output logic            irq_b
);

    logic [PINS-1:0] trig_vec;
    logic [PINS-1:0] live_vec;

    assign live_vec = ~pin_dir & pin_en;

    // One qualifier cell per pin.
    for (genvar g = 0; g < PINS; g++) begin : g_pin
        gpio_pin_cell u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .pin_lvl  (pin_in[g]),
            .is_output(pin_dir[g]),
            .buf_en   (pin_en[g]),
            .pol      (polarity[g]),
            .edge_bit (edge_sel[g]),
            .any_bit  (any_edge[g]),
            .stored   (sample_q[g]),
            .trig     (trig_vec[g])
        );
    end

    gpio_irq_merge #(.PINS(PINS)) u_merge (
        .clk     (clk),
        .rst_n   (rst_n),
        .trig_vec(trig_vec),
        .mask_a  (route_a),
        .mask_b  (route_b),
        .req_a   (irq_a),
        .req_b   (irq_b)
    );

    // R8: with every pin in edge mode and no input differing from the
    // stored level, no request follows.
    p_edge_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((&edge_sel) && (pin_in == sample_q)) |=> (!irq_a && !irq_b));

    // R6: a live level-mode pin at its active level, routed to A, raises A.
    p_level_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((~edge_sel & live_vec & (pin_in ^ polarity) & route_a) != '0) |=> irq_a);

endmodule

// File: tb/gpio_irq_qualifier_test.sv
module gpio_irq_qualifier_test;

    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] pin_in = '0, pin_dir = '0, pin_en = '1, polarity = '0;
    logic [W-1:0] edge_sel = '1, any_edge = '0, route_a = '0, route_b = '0;
    logic [W-1:0] sample_q;
    logic         irq_a, irq_b;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    gpio_irq_qualifier #(.PINS(W)) uut (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .pin_dir(pin_dir),
        .pin_en(pin_en), .polarity(polarity), .edge_sel(edge_sel),
        .any_edge(any_edge), .route_a(route_a), .route_b(route_b),
        .sample_q(sample_q), .irq_a(irq_a), .irq_b(irq_b)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", tag, got, exp);
        end
    endtask

    // Called at a negedge: apply pins, pass one rising edge, return at negedge.
    task automatic step(input logic [W-1:0] p);
        pin_in = p;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 sample", sample_q, 0);
        chk("R1 irq_a", irq_a, 0);
        chk("R1 irq_b", irq_b, 0);
    endtask

    task automatic t_capture();
        edge_sel = '1; any_edge = '0; route_a = '0; route_b = '0;
        step(16'hA5C3);
        chk("R2 capture1", sample_q, 16'hA5C3);
        step(16'h3C5A);
        chk("R2 capture2", sample_q, 16'h3C5A);
        chk("R2 no route irq", {irq_a, irq_b}, 0);
    endtask

    task automatic t_disabled();
        step(16'h0000);
        pin_dir = 16'h0001; pin_en = 16'hFFFD;
        any_edge = '1; route_a = 16'h0003; route_b = 16'h0003;
        step(16'h0003);
        chk("R3 hold", sample_q, 16'h0000);
        chk("R3 no irq", {irq_a, irq_b}, 0);
        pin_dir = '0; pin_en = '1; route_a = '0; route_b = '0;
        step(16'h0000);
    endtask

    task automatic t_any_edge();
        edge_sel = '1; any_edge = '1; route_a = 16'h0008; route_b = '0;
        step(16'h0008);
        chk("R4 rise", irq_a, 1);
        step(16'h0008);
        chk("R4 steady none / R8 pulse", irq_a, 0);
        step(16'h0000);
        chk("R4 fall", irq_a, 1);
        step(16'h0000);
        chk("R8 pulse ends", irq_a, 0);
    endtask

    task automatic t_single_edge();
        any_edge = '0; polarity = '0; route_a = 16'h0008;
        step(16'h0008);
        chk("R5 pol0 rise", irq_a, 1);
        step(16'h0000);
        chk("R5 pol0 fall none", irq_a, 0);
        polarity = 16'h0008;
        step(16'h0008);
        chk("R5 pol1 rise none", irq_a, 0);
        step(16'h0000);
        chk("R5 pol1 fall", irq_a, 1);
        step(16'h0000);
        polarity = '0;
    endtask

    task automatic t_level();
        edge_sel = '0; polarity = '0; route_a = 16'h0008; route_b = '0;
        step(16'h0008);
        chk("R6 high c1", irq_a, 1);
        step(16'h0008);
        chk("R6 high c2", irq_a, 1);
        step(16'h0000);
        chk("R6 released", irq_a, 0);
        polarity = 16'h0008;
        step(16'h0000);
        chk("R6 active low", irq_a, 1);
        step(16'h0008);
        chk("R6 inactive high", irq_a, 0);
        polarity = '0;
        edge_sel = '1; route_a = '0;
        step(16'h0000);
    endtask

    task automatic t_route();
        edge_sel = '1; any_edge = '1;
        route_a = 16'h0010; route_b = '0;
        step(16'h0010);
        chk("R7 a only", {irq_a, irq_b}, 2'b10);
        route_a = '0; route_b = 16'h0010;
        step(16'h0000);
        chk("R7 b only", {irq_a, irq_b}, 2'b01);
        route_a = 16'h0010;
        step(16'h0010);
        chk("R7 both", {irq_a, irq_b}, 2'b11);
        route_a = 16'h0001; route_b = 16'h0001;
        step(16'h0000);
        chk("R7 neither", {irq_a, irq_b}, 2'b00);
    endtask

    task automatic t_or();
        route_a = 16'h8000; route_b = 16'h0100;
        step(16'h8100);
        chk("R9 two pins", {irq_a, irq_b}, 2'b11);
        route_a = 16'h8100; route_b = '0;
        step(16'h8000);
        chk("R9 one of two", {irq_a, irq_b}, 2'b10);
        route_a = '0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_capture();
        t_disabled();
        t_any_edge();
        t_single_edge();
        t_level();
        t_route();
        t_or();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule